// File: doc/BRIEF.md
# Operand and Store Pairing Queues

This block sits between the access engine and the compute engine of a decoupled processor. It holds three first-in first-out queues. The operand queue moves fetched operands from the access side to the compute side. Each of its entries carries one extra flag that turns it into an end-of-data token, which tells the compute loop that the current stream has ended. The remaining two queues collect the two halves of every store. Destination addresses arrive from the access engine, and result values arrive from the compute engine, each at its own pace.

A joining stage watches the heads of both store queues. Whenever each of them holds an entry, it offers one write request made of the oldest address and the oldest value. Both heads leave their queues in the cycle the memory side accepts that request. Because each store half is buffered on its own, either engine can run ahead of the other until its own queue fills. All streams use valid/ready handshakes, and a transfer happens on a rising clock edge where valid and ready are both high.

Top module: `dcpl_xfer_queues`

## Requirements
- R1: After reset all three queues are empty. The three empty flags are high, the three push readies are high, `ld_pop_valid` is low and `wr_valid` is low.
- R2: Operands leave the operand queue in exactly the order they were pushed.
- R3: A push with `ld_push_eod` high stores an end-of-data token in its queue position. It is delivered with `ld_pop_eod` high and `ld_pop_data` all zero, whatever data came with the push.
- R4: `wr_valid` is high only while both the store address queue and the store data queue are non-empty. An address or a value on its own raises no request.
- R5: The Nth address pushed is always written together with the Nth value pushed.
- R6: While `wr_valid` is high and `wr_ready` is low, the request holds with unchanged `wr_addr` and `wr_data`. Both heads are removed in the single cycle where `wr_valid` and `wr_ready` are both high.
- R7: Each queue holds DEPTH entries (default 128). When a queue is full its push ready is low, and a push offered while full is dropped.
- R8: Each empty flag is high exactly when its queue holds no entries. `ld_pop_valid` equals the inverse of `ld_empty`.
- R9: A full store address queue does not stop pushes into the store data queue, and the reverse also holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_push_valid | input | 1 | Access side offers an operand or token |
| ld_push_ready | output | 1 | Operand queue has room |
| ld_push_data | input | DATA_W | Operand value |
| ld_push_eod | input | 1 | Marks the push as an end-of-data token |
| ld_pop_valid | output | 1 | An operand or token waits at the head |
| ld_pop_ready | input | 1 | Compute side takes the head |
| ld_pop_data | output | DATA_W | Head operand, zero for a token |
| ld_pop_eod | output | 1 | Head is an end-of-data token |
| ld_empty | output | 1 | Operand queue empty |
| sa_push_valid | input | 1 | Access side offers a store address |
| sa_push_ready | output | 1 | Store address queue has room |
| sa_push_addr | input | ADDR_W | Store address |
| sa_empty | output | 1 | Store address queue empty |
| sd_push_valid | input | 1 | Compute side offers a store value |
| sd_push_ready | output | 1 | Store data queue has room |
| sd_push_data | input | DATA_W | Store value |
| sd_empty | output | 1 | Store data queue empty |
| wr_valid | output | 1 | Paired write request offered |
| wr_ready | input | 1 | Memory side accepts the write |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Write value |

## Verification
The bench queues several addresses before any value exists, to confirm that a lone address raises no write. A joiner that looked at only one queue would issue a write carrying stale data. It then holds `wr_ready` low for several cycles. A design that popped on valid alone, or let the head move while stalled, would lose pairs or show a changing address. It fills the address queue completely, offers one more address, and checks that the data queue still accepts values. After draining, a wrong full check or a wrong pointer wrap would show up as a 129th write, a misordered pair, or a queue that never reads empty. An end-of-data token is pushed with non-zero data to catch a design that leaks the payload or loses the flag.

// File: rtl/dcpl_pkg.sv
package dcpl_pkg;

  // Next slot index in a circular buffer of `depth` slots.
  function automatic int unsigned slot_after(int unsigned idx, int unsigned depth);
    return (idx + 1 == depth) ? 0 : idx + 1;
  endfunction

  // Occupancy after one cycle with optional insert and removal.
  function automatic int unsigned occ_after(int unsigned occ, bit put, bit take);
    return occ + (put ? 1 : 0) - (take ? 1 : 0);
  endfunction

  // Payload actually stored for an operand-queue push; tokens carry nothing.
  function automatic logic [63:0] token_payload(logic [63:0] raw, bit is_eod);
    return is_eod ? 64'd0 : raw;
  endfunction

endpackage

// File: rtl/dcpl_fifo.sv
module dcpl_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data,
  output logic             empty
);
  import dcpl_pkg::*;

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    rd_ptr, wr_ptr;
  logic [CW-1:0]    occ;
  logic             do_put, do_take;

  assign in_ready  = (occ != CW'(DEPTH));
  assign empty     = (occ == '0);
  assign out_valid = !empty;
  assign out_data  = mem[rd_ptr];
  assign do_put    = in_valid && in_ready;
  assign do_take   = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (do_put) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      occ    <= '0;
    end else begin
      if (do_put)  wr_ptr <= PW'(slot_after(32'(wr_ptr), DEPTH));
      if (do_take) rd_ptr <= PW'(slot_after(32'(rd_ptr), DEPTH));
      occ <= CW'(occ_after(32'(occ), do_put, do_take));
    end
  end
endmodule

// File: rtl/dcpl_store_join.sv
module dcpl_store_join #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              addr_avail,
  input  logic [ADDR_W-1:0] addr_head,
  input  logic              data_avail,
  input  logic [DATA_W-1:0] data_head,
  output logic              addr_take,
  output logic              data_take,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic pair_fire;

  assign wr_valid  = addr_avail && data_avail;
  assign wr_addr   = addr_head;
  assign wr_data   = data_head;
  assign pair_fire = wr_valid && wr_ready;
  assign addr_take = pair_fire;
  assign data_take = pair_fire;
endmodule

// File: rtl/dcpl_xfer_queues.sv
module dcpl_xfer_queues #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_push_valid,
  output logic              ld_push_ready,
  input  logic [DATA_W-1:0] ld_push_data,
  input  logic              ld_push_eod,
  output logic              ld_pop_valid,
  input  logic              ld_pop_ready,
  output logic [DATA_W-1:0] ld_pop_data,
  output logic              ld_pop_eod,
  output logic              ld_empty,
  input  logic              sa_push_valid,
  output logic              sa_push_ready,
  input  logic [ADDR_W-1:0] sa_push_addr,
  output logic              sa_empty,
  input  logic              sd_push_valid,
  output logic              sd_push_ready,
  input  logic [DATA_W-1:0] sd_push_data,
  output logic              sd_empty,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  import dcpl_pkg::*;

  localparam int LW = DATA_W + 1;

  logic [LW-1:0]     ld_in_entry, ld_head_entry;
  logic [63:0]       ld_raw_wide;
  logic              sa_head_valid, sd_head_valid;
  logic [ADDR_W-1:0] sa_head;
  logic [DATA_W-1:0] sd_head;
  logic              sa_take, sd_take;

  assign ld_raw_wide = 64'(ld_push_data);
  assign ld_in_entry = {ld_push_eod, DATA_W'(token_payload(ld_raw_wide, ld_push_eod))};
  assign ld_pop_eod  = ld_head_entry[LW-1];
  assign ld_pop_data = ld_head_entry[DATA_W-1:0];

  dcpl_fifo #(.WIDTH(LW), .DEPTH(DEPTH)) u_ld_q (
    .clk(clk), .rst_n(rst_n),
    .in_valid(ld_push_valid), .in_ready(ld_push_ready), .in_data(ld_in_entry),
    .out_valid(ld_pop_valid), .out_ready(ld_pop_ready), .out_data(ld_head_entry),
    .empty(ld_empty)
  );

  dcpl_fifo #(.WIDTH(ADDR_W), .DEPTH(DEPTH)) u_sa_q (
    .clk(clk), .rst_n(rst_n),
    .in_valid(sa_push_valid), .in_ready(sa_push_ready), .in_data(sa_push_addr),
    .out_valid(sa_head_valid), .out_ready(sa_take), .out_data(sa_head),
    .empty(sa_empty)
  );

  dcpl_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_sd_q (
    .clk(clk), .rst_n(rst_n),
    .in_valid(sd_push_valid), .in_ready(sd_push_ready), .in_data(sd_push_data),
    .out_valid(sd_head_valid), .out_ready(sd_take), .out_data(sd_head),
    .empty(sd_empty)
  );

  dcpl_store_join #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_join (
    .addr_avail(sa_head_valid), .addr_head(sa_head),
    .data_avail(sd_head_valid), .data_head(sd_head),
    .addr_take(sa_take), .data_take(sd_take),
    .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );
endmodule

// File: rtl/dcpl_xfer_queues_chk.sv
module dcpl_xfer_queues_chk #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_push_valid,
  input logic              ld_push_ready,
  input logic              ld_pop_valid,
  input logic              ld_pop_ready,
  input logic [DATA_W-1:0] ld_pop_data,
  input logic              ld_pop_eod,
  input logic              ld_empty,
  input logic              sa_push_valid,
  input logic              sa_push_ready,
  input logic              sa_empty,
  input logic              sd_push_valid,
  input logic              sd_push_ready,
  input logic              sd_empty,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data
);
  localparam int CW = $clog2(DEPTH + 1);

  // Shadow occupancies rebuilt from port handshakes only.
  logic [CW-1:0] ld_n, sa_n, sd_n;
  logic ld_in, ld_out, sa_in, sd_in, wr_go;

  assign ld_in  = ld_push_valid && ld_push_ready;
  assign ld_out = ld_pop_valid && ld_pop_ready;
  assign sa_in  = sa_push_valid && sa_push_ready;
  assign sd_in  = sd_push_valid && sd_push_ready;
  assign wr_go  = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_n <= '0; sa_n <= '0; sd_n <= '0;
    end else begin
      ld_n <= ld_n + CW'(ld_in) - CW'(ld_out);
      sa_n <= sa_n + CW'(sa_in) - CW'(wr_go);
      sd_n <= sd_n + CW'(sd_in) - CW'(wr_go);
    end
  end

  p_ld_full_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_push_ready == (ld_n != CW'(DEPTH)));
  p_sa_full_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sa_push_ready == (sa_n != CW'(DEPTH)));
  p_sd_full_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sd_push_ready == (sd_n != CW'(DEPTH)));
  p_empty_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_empty == (ld_n == '0)) && (sa_empty == (sa_n == '0)) && (sd_empty == (sd_n == '0)));
  p_pop_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_pop_valid == (ld_n != '0));
  p_token_no_payload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_pop_valid && ld_pop_eod) |-> (ld_pop_data == '0));
  p_write_needs_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ((sa_n != '0) && (sd_n != '0)));
  p_stall_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
endmodule

bind dcpl_xfer_queues dcpl_xfer_queues_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .ld_push_valid(ld_push_valid), .ld_push_ready(ld_push_ready),
  .ld_pop_valid(ld_pop_valid), .ld_pop_ready(ld_pop_ready),
  .ld_pop_data(ld_pop_data), .ld_pop_eod(ld_pop_eod), .ld_empty(ld_empty),
  .sa_push_valid(sa_push_valid), .sa_push_ready(sa_push_ready), .sa_empty(sa_empty),
  .sd_push_valid(sd_push_valid), .sd_push_ready(sd_push_ready), .sd_empty(sd_empty),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/dcpl_xfer_queues_tb_top.sv
module dcpl_xfer_queues_tb_top;
  localparam int DEPTH  = 128;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_push_valid = 0, ld_push_eod = 0, ld_pop_ready = 0;
  logic [DATA_W-1:0] ld_push_data = '0;
  logic sa_push_valid = 0, sd_push_valid = 0, wr_ready = 0;
  logic [ADDR_W-1:0] sa_push_addr = '0;
  logic [DATA_W-1:0] sd_push_data = '0;
  logic ld_push_ready, ld_pop_valid, ld_pop_eod, ld_empty;
  logic [DATA_W-1:0] ld_pop_data;
  logic sa_push_ready, sa_empty, sd_push_ready, sd_empty, wr_valid;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  dcpl_xfer_queues #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic push_ld(input logic [DATA_W-1:0] d, input logic e);
    chk(ld_push_ready, "R7 ld ready", ld_push_ready, 1);
    ld_push_valid = 1; ld_push_data = d; ld_push_eod = e;
    tick();
    ld_push_valid = 0; ld_push_eod = 0;
  endtask

  task automatic push_sa(input logic [ADDR_W-1:0] a);
    sa_push_valid = 1; sa_push_addr = a;
    tick();
    sa_push_valid = 0;
  endtask

  task automatic push_sd(input logic [DATA_W-1:0] d);
    sd_push_valid = 1; sd_push_data = d;
    tick();
    sd_push_valid = 0;
  endtask

  task automatic t_reset();
    chk(ld_empty && sa_empty && sd_empty, "R1 empties", {ld_empty, sa_empty, sd_empty}, 7);
    chk(ld_push_ready && sa_push_ready && sd_push_ready, "R1 readies",
        {ld_push_ready, sa_push_ready, sd_push_ready}, 7);
    chk(!ld_pop_valid && !wr_valid, "R1 no output", {ld_pop_valid, wr_valid}, 0);
  endtask

  task automatic t_load_order();
    logic [DATA_W-1:0] vals [4] = '{32'h11, 32'h22, 32'h33, 32'hDEAD};
    push_ld(vals[0], 0); push_ld(vals[1], 0); push_ld(vals[2], 0); push_ld(vals[3], 1);
    chk(!ld_empty && ld_pop_valid, "R8 not empty", ld_empty, 0);
    for (int i = 0; i < 4; i++) begin
      if (i < 3) begin
        chk(ld_pop_data == vals[i], "R2 order", ld_pop_data, vals[i]);
        chk(!ld_pop_eod, "R3 no eod", ld_pop_eod, 0);
      end else begin
        chk(ld_pop_eod, "R3 eod flag", ld_pop_eod, 1);
        chk(ld_pop_data == '0, "R3 token payload", ld_pop_data, 0);
      end
      ld_pop_ready = 1; tick(); ld_pop_ready = 0;
    end
    chk(ld_empty && !ld_pop_valid, "R8 empty after drain", ld_empty, 1);
  endtask

  task automatic t_pairing();
    push_sa(32'hA0); push_sa(32'hA1); push_sa(32'hA2);
    chk(!wr_valid, "R4 lone address", wr_valid, 0);
    chk(!sa_empty && sd_empty, "R8 flags", {sa_empty, sd_empty}, 2'b01);
    push_sd(32'hD0);
    for (int k = 0; k < 3; k++) begin
      chk(wr_valid && wr_addr == 32'hA0 && wr_data == 32'hD0, "R6 held while stalled",
          {wr_addr[15:0], wr_data[15:0]}, 32'h00A000D0);
      tick();
    end
    wr_ready = 1; tick(); wr_ready = 0;
    chk(!wr_valid && !sa_empty && sd_empty, "R6 single pop", {wr_valid, sa_empty, sd_empty}, 3'b001);
    push_sd(32'hD1); push_sd(32'hD2);
    chk(wr_valid && wr_addr == 32'hA1 && wr_data == 32'hD1, "R5 second pair",
        {wr_addr[15:0], wr_data[15:0]}, 32'h00A100D1);
    wr_ready = 1; tick();
    chk(wr_valid && wr_addr == 32'hA2 && wr_data == 32'hD2, "R5 third pair",
        {wr_addr[15:0], wr_data[15:0]}, 32'h00A200D2);
    tick(); wr_ready = 0;
    chk(!wr_valid && sa_empty && sd_empty, "R6 both drained", {wr_valid, sa_empty, sd_empty}, 3'b011);
  endtask

  task automatic t_fill();
    for (int i = 0; i < DEPTH; i++) push_sa(ADDR_W'(32'h1000 + i));
    chk(!sa_push_ready, "R7 addr full", sa_push_ready, 0);
    chk(sd_push_ready && !wr_valid, "R9 data still open", sd_push_ready, 1);
    push_sa(32'hBAD);
    for (int i = 0; i < DEPTH; i++) push_sd(DATA_W'(32'h5000 + i));
    chk(!sd_push_ready, "R7 data full", sd_push_ready, 0);
    wr_ready = 1;
    for (int i = 0; i < DEPTH; i++) begin
      chk(wr_valid && wr_addr == ADDR_W'(32'h1000 + i) && wr_data == DATA_W'(32'h5000 + i),
          "R5 deep pair", wr_addr, 32'h1000 + i);
      tick();
    end
    wr_ready = 0;
    chk(!wr_valid && sa_empty && sd_empty, "R7 overflow push dropped",
        {wr_valid, sa_empty, sd_empty}, 3'b011);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    t_reset();
    t_load_order();
    t_pairing();
    t_fill();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_checks++; n_fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule